// File: doc/BRIEF.md
# Time-Slotted Memory Bus Scheduler

This block sequences a pipelined 64-bit SRAM bus that four clients share: the processor port, two network receivers and one network transmitter. A two-bit slot counter hands the address bus to one client per cycle, in a fixed four-cycle rotation. A read's data appears on the data bus two cycles after its address. A write raises the write strobe first, puts its data on the bus in the next cycle, and sends its address two cycles after the data. With this skew, every client's reads and writes meet the memory in its own slot, and no owner ever needs an acknowledgment.

Network clients announce one cycle ahead, through a bus-wanted bit, whether they will use their coming address slot and the data slot that follows it. A silent network client lends both slots to the processor, which may place a pending read there. Writes and requests arriving from the host side are served only in the processor's own slot. The scheduler holds one pending processor-side request. It serves a read in whichever of its own slot or a lendable network slot comes first, and it marks every read return with a tag that says which kind of slot produced it.

Top module: `mem_slot_sched`

## Requirements
- R1: `slot` is 0 in reset and advances by one every cycle, wrapping from 3 to 0. The encoding is 0 = processor port, 1 = first receiver, 2 = second receiver, 3 = transmitter.
- R2: For network client c (1..3), `addr_en[c]` is high exactly in the cycles where `slot == c` and `net_want[c]` was high in the previous cycle.
- R3: For network client c, `data_en[c]` is high exactly in the cycles where `slot == (c+2) mod 4` and `net_want[c]` was high three cycles earlier.
- R4: A pending read that is present in a slot-0 cycle, when that cycle carries no write address, drives `addr_en[0]` in that cycle. Two cycles later (slot 2), `rd_ret` and `data_en[0]` are high and `ret_tag` is 0.
- R5: A pending write that is present in a slot-1 cycle raises `mem_we` in that cycle and `cpu_dout_en` and `data_en[0]` in the next cycle. It raises `addr_en[0]` two cycles after the data, in slot 0. A write never uses a network slot.
- R6: A pending processor read (not from the host) that is present in the slot of network client c, where `net_want[c]` was low in the previous cycle, raises `borrow` and `addr_en[0]` in that cycle. Two cycles later, `rd_ret` and `data_en[0]` are high and `ret_tag` is 1.
- R7: A slot-0 cycle that carries a write's address cannot serve a pending read. The read stays pending (`busy` high) until the next own or lendable slot.
- R8: A request taken while `host_mode` is high never borrows. `host_en` is high in every cycle where its address is driven, and only then.
- R9: At most one request is pending. `cpu_go` is taken only while `busy` is low. `busy` is high from the cycle after acceptance through the cycle in which the read issues or the write commits.
- R10: At most one bit of `addr_en` and at most one bit of `data_en` are high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| net_want | input | 3 | Bus-wanted per network client, bits 3:1, given the cycle before that client's slot |
| cpu_go | input | 1 | Request strobe from the processor side |
| cpu_write | input | 1 | Request is a write (1) or a read (0) |
| host_mode | input | 1 | Request comes from the host side |
| slot | output | 2 | Current address-slot owner |
| addr_en | output | 4 | Address-bus drive enable per client (bit 0 = processor port) |
| data_en | output | 4 | Data-bus window per client |
| mem_we | output | 1 | Write strobe for a processor-side write |
| cpu_dout_en | output | 1 | Processor port drives write data |
| rd_ret | output | 1 | Read data for the processor port is on the bus |
| ret_tag | output | 1 | Returning read came from a borrowed slot |
| borrow | output | 1 | Processor port uses a lent network address slot |
| host_en | output | 1 | Processor-port address cycle belongs to the host |
| busy | output | 1 | A request is pending |

## Verification
The hardest case to reach from the ports is a read stalled behind a write's address. It needs a write committed in slot 1, a read taken in the very next cycle, and a transmitter that asserts bus-wanted, so that the slot-3 borrow is refused before the read meets the occupied slot 0. The stimulus reaches it with a phase that keeps every bus-wanted bit high and holds the request strobe asserted with alternating write and read types, so each accepted write is followed at once by a read. Random phases then mix lending, host traffic and strobes issued while busy, and a cycle-exact reference model is compared against the outputs.

// File: rtl/mem_slot_sched.sv
module mem_slot_sched (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:1] net_want,
  input  logic       cpu_go,
  input  logic       cpu_write,
  input  logic       host_mode,
  output logic [1:0] slot,
  output logic [3:0] addr_en,
  output logic [3:0] data_en,
  output logic       mem_we,
  output logic       cpu_dout_en,
  output logic       rd_ret,
  output logic       ret_tag,
  output logic       borrow,
  output logic       host_en,
  output logic       busy
);

  localparam logic [1:0] CPU_SLOT    = 2'd0;
  localparam logic [1:0] COMMIT_SLOT = CPU_SLOT + 2'd1;

  logic [1:0] s_q, s_nx;
  logic [3:0] want_vec;
  logic       want_q, wq1_q, wq2_q;
  logic       pend_q, pwr_q, phost_q;
  logic       wd_q, wm_q, wa_q, wh_q;
  logic       rp1_q, rp2_q, rt1_q, rt2_q;
  logic       own_rd, brw, commit_w, issue, accept;

  assign s_nx     = s_q + 2'd1;
  assign want_vec = {net_want, 1'b0};

  assign own_rd   = (s_q == CPU_SLOT) && pend_q && !pwr_q && !wa_q;
  assign brw      = (s_q != CPU_SLOT) && !want_q && pend_q && !pwr_q && !phost_q;
  assign commit_w = (s_q == COMMIT_SLOT) && pend_q && pwr_q;
  assign issue    = own_rd || brw;
  assign accept   = cpu_go && !pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_q     <= CPU_SLOT;
      want_q  <= 1'b0;
      wq1_q   <= 1'b0;
      wq2_q   <= 1'b0;
      pend_q  <= 1'b0;
      pwr_q   <= 1'b0;
      phost_q <= 1'b0;
      wd_q    <= 1'b0;
      wm_q    <= 1'b0;
      wa_q    <= 1'b0;
      wh_q    <= 1'b0;
      rp1_q   <= 1'b0;
      rp2_q   <= 1'b0;
      rt1_q   <= 1'b0;
      rt2_q   <= 1'b0;
    end else begin
      s_q    <= s_nx;
      want_q <= want_vec[s_nx];
      wq1_q  <= want_q;
      wq2_q  <= wq1_q;
      if (accept) begin
        pend_q  <= 1'b1;
        pwr_q   <= cpu_write;
        phost_q <= host_mode;
      end else if (issue || commit_w) begin
        pend_q  <= 1'b0;
      end
      wd_q  <= commit_w;
      wm_q  <= wd_q;
      wa_q  <= wm_q;
      if (commit_w) wh_q <= phost_q;
      rp1_q <= issue;
      rt1_q <= brw;
      rp2_q <= rp1_q;
      rt2_q <= rt1_q;
    end
  end

  for (genvar c = 1; c < 4; c++) begin : g_net
    assign addr_en[c] = (s_q == 2'(c)) && want_q;
    assign data_en[c] = (s_q == 2'((c + 2) % 4)) && wq2_q;
  end

  assign addr_en[0]  = issue || wa_q;
  assign data_en[0]  = wd_q || rp2_q;
  assign slot        = s_q;
  assign mem_we      = commit_w;
  assign cpu_dout_en = wd_q;
  assign rd_ret      = rp2_q;
  assign ret_tag     = rt2_q;
  assign borrow      = brw;
  assign host_en     = (issue && phost_q) || (wa_q && wh_q);
  assign busy        = pend_q;

  // R1
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> slot == $past(slot) + 2'd1);

  // R10
  addr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(addr_en));

  // R10
  data_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(data_en));

  // R5
  we_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_we) |-> cpu_dout_en && slot == CPU_SLOT + 2'd2);

  // R5
  data_then_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_dout_en, 2) |-> addr_en[0] && slot == CPU_SLOT);

  // R6
  borrow_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(borrow, 2) |-> rd_ret && ret_tag && data_en[0]);

  // R4
  own_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ret && !ret_tag |-> slot == CPU_SLOT + 2'd2);

  // R8
  host_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_en |-> slot == CPU_SLOT && !borrow && addr_en[0]);

endmodule

// File: tb/mem_slot_sched_test.sv
module mem_slot_sched_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:1] net_want = '0;
  logic       cpu_go = 1'b0, cpu_write = 1'b0, host_mode = 1'b0;
  logic [1:0] slot;
  logic [3:0] addr_en, data_en;
  logic       mem_we, cpu_dout_en, rd_ret, ret_tag, borrow, host_en, busy;

  mem_slot_sched uut (
    .clk(clk), .rst_n(rst_n), .net_want(net_want), .cpu_go(cpu_go),
    .cpu_write(cpu_write), .host_mode(host_mode), .slot(slot),
    .addr_en(addr_en), .data_en(data_en), .mem_we(mem_we),
    .cpu_dout_en(cpu_dout_en), .rd_ret(rd_ret), .ret_tag(ret_tag),
    .borrow(borrow), .host_en(host_en), .busy(busy)
  );

  always #10 clk = ~clk;

  localparam int NCYC = 4000;
  int tests = 0, fails = 0;
  int blocked_seen = 0, borrow_seen = 0, own_seen = 0, write_seen = 0;
  logic [3:1] wh [0:NCYC];
  bit ev_a0 [0:NCYC+8];
  bit ev_host [0:NCYC+8];
  bit ev_we [0:NCYC+8];
  bit ev_dout [0:NCYC+8];
  bit ev_ret [0:NCYC+8];
  bit ev_tag [0:NCYC+8];
  bit m_pend = 0, m_wr = 0, m_host = 0;
  bit last_was_read = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp, input int k);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: got %0h expected %0h", req, k, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 reset slot", 8'(slot), 8'd0, -1);
    chk("R2 reset addr_en", 8'(addr_en), 8'd0, -1);
    chk("R3 reset data_en", 8'(data_en), 8'd0, -1);
    chk("R9 reset busy", 8'(busy), 8'd0, -1);
    rst_n = 1'b1;
    for (int k = 0; k < NCYC; k++) begin
      int s;
      logic [3:1] w_prev, w3;
      logic [3:0] e_addr, e_data;
      bit iss_own, iss_brw, cmt, pend_before, e_hosten;
      if (k > 0) @(negedge clk);
      s = k % 4;
      w_prev = (k >= 1) ? wh[k-1] : 3'b000;
      w3     = (k >= 3) ? wh[k-3] : 3'b000;
      iss_own = m_pend && !m_wr && s == 0 && !ev_a0[k];
      iss_brw = m_pend && !m_wr && !m_host && s != 0 && !w_prev[s];
      cmt     = m_pend && m_wr && s == 1;
      if (iss_own || iss_brw) begin
        ev_ret[k+2] = 1'b1;
        ev_tag[k+2] = iss_brw;
      end
      if (cmt) begin
        ev_we[k] = 1'b1;
        ev_dout[k+1] = 1'b1;
        ev_a0[k+3] = 1'b1;
        ev_host[k+3] = m_host;
      end
      e_addr = '0;
      e_data = '0;
      for (int c = 1; c < 4; c++) begin
        e_addr[c] = (s == c) && w_prev[c];
        e_data[c] = (s == (c + 2) % 4) && w3[c];
      end
      e_addr[0] = iss_own || iss_brw || ev_a0[k];
      e_data[0] = ev_dout[k] || ev_ret[k];
      e_hosten  = ((iss_own || iss_brw) && m_host) || (ev_a0[k] && ev_host[k]);

      chk("R1 slot", 8'(slot), 8'(s), k);
      chk("R2 net addr_en", 8'(addr_en[3:1]), 8'(e_addr[3:1]), k);
      chk("R3 net data_en", 8'(data_en[3:1]), 8'(e_data[3:1]), k);
      chk("R4 R6 processor addr_en", 8'(addr_en[0]), 8'(e_addr[0]), k);
      chk("R4 R5 processor data_en", 8'(data_en[0]), 8'(e_data[0]), k);
      chk("R5 mem_we", 8'(mem_we), 8'(ev_we[k]), k);
      chk("R5 cpu_dout_en", 8'(cpu_dout_en), 8'(ev_dout[k]), k);
      chk("R4 R6 rd_ret", 8'(rd_ret), 8'(ev_ret[k]), k);
      if (ev_ret[k]) chk("R4 R6 ret_tag", 8'(ret_tag), 8'(ev_tag[k]), k);
      chk("R6 borrow", 8'(borrow), 8'(iss_brw), k);
      chk("R8 host_en", 8'(host_en), 8'(e_hosten), k);
      chk("R9 busy", 8'(busy), 8'(m_pend), k);
      chk("R10 addr exclusive", 8'($countones(addr_en) <= 1), 8'd1, k);
      chk("R10 data exclusive", 8'($countones(data_en) <= 1), 8'd1, k);
      if (m_pend && !m_wr && s == 0 && ev_a0[k]) begin
        blocked_seen++;
        chk("R7 read held behind write address", 8'(busy && !rd_ret), 8'd1, k);
      end
      if (iss_brw) borrow_seen++;
      if (iss_own) own_seen++;
      if (cmt) write_seen++;

      pend_before = m_pend;
      if (iss_own || iss_brw || cmt) m_pend = 1'b0;

      if (k < 60) begin
        net_want = 3'b111;
        cpu_go = (k % 3 == 0);
        cpu_write = 1'b0;
        host_mode = 1'b0;
      end else if (k < 120) begin
        net_want = 3'b000;
        cpu_go = 1'b1;
        cpu_write = 1'b0;
        host_mode = 1'b0;
      end else if (k < 260) begin
        net_want = 3'b111;
        cpu_go = 1'b1;
        cpu_write = last_was_read;
        host_mode = 1'b0;
      end else if (k < 400) begin
        net_want = 3'($urandom);
        cpu_go = ($urandom % 2) == 0;
        cpu_write = ($urandom % 3) == 0;
        host_mode = 1'b1;
      end else begin
        net_want = 3'($urandom);
        cpu_go = ($urandom % 2) == 0;
        cpu_write = ($urandom % 3) == 0;
        host_mode = ($urandom % 5) == 0;
      end
      wh[k] = net_want;
      if (cpu_go && !pend_before) begin
        m_pend = 1'b1;
        m_wr = cpu_write;
        m_host = host_mode;
        last_was_read = !cpu_write;
      end
    end
    // R7 R6 R4 R5 coverage of the corner cases
    chk("R7 blocked read reached", 8'(blocked_seen > 0), 8'd1, NCYC);
    chk("R6 borrowed read reached", 8'(borrow_seen > 0), 8'd1, NCYC);
    chk("R4 own-slot read reached", 8'(own_seen > 0), 8'd1, NCYC);
    chk("R5 write reached", 8'(write_seen > 0), 8'd1, NCYC);
    finish_run();
  end
endmodule